// File: doc/BRIEF.md
# Supply and Bus-Activity Reset Supervisor

This block drives the active-low reset line of a processor from two sources. The first is a digital supply-good flag from an external comparator. Whenever that flag is low, reset is held. After the flag returns, reset stays asserted until the flag has been high for an uninterrupted power-up delay.

The second source is a watchdog that measures the time since the last START condition on a two-wire serial bus. The SCL and SDA lines are sampled, and a START is SDA falling while SCL is high. If no START arrives within the selected period, the watchdog pulses reset for a fixed width and then times again from zero.

All timing is counted in ticks of a 1 ms timebase strobe, and every delay is a parameter. A bus-inhibit flag mirrors the reset output, so a neighbouring serial slave can abort the transfer it is handling and refuse new ones while reset is active.

Top module: `sup_wd_reset`

## Requirements
- R1: The supply flag passes through a 2-flop synchronizer. When the flag goes low, `rst_n_o` goes low within 4 clock cycles and stays low while the flag is low.
- R2: `rst_n_o` returns high only after `PWRUP_MS` ticks seen while the synchronized supply flag is continuously high. A drop of the flag before that count completes restarts the count from zero.
- R3: While `rst_i` is high, and in the first cycle after it falls, `rst_n_o` is 0 and `bus_inhibit_o` is 1. Reset then remains active until R2 is met.
- R4: The timeout select `wd_sel_i` is encoded as follows:

  | Code | Timeout |
  |------|---------|
  | 2'b00 | `WD_LONG_MS` ticks |
  | 2'b01 | `WD_MID_MS` ticks |
  | 2'b10 | `WD_SHORT_MS` ticks |
  | 2'b11 | watchdog disabled |

  While the code is 2'b11, or while the supply reset is active, the watchdog count is held at zero and any watchdog reset pulse is cancelled.
- R5: When the selected number of ticks passes without a START, `rst_n_o` goes low for exactly `WDRST_MS` ticks. The watchdog then restarts timing from zero.
- R6: A START condition clears the watchdog count. START means synchronized SDA going from 1 to 0 while synchronized SCL is 1.
- R7: An SDA fall while SCL is low has no effect on the watchdog count. A START during a watchdog reset pulse neither shortens nor restarts the pulse.
- R8: A supply drop during a watchdog reset pulse turns the pulse into a supply reset. Reset is then held for the full power-up delay after the supply returns.
- R9: `bus_inhibit_o` is 1 in exactly the cycles where `rst_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-good flag from external comparator (asynchronous) |
| scl_i | input | 1 | Sampled serial clock line (asynchronous) |
| sda_i | input | 1 | Sampled serial data line (asynchronous) |
| wd_sel_i | input | 2 | Watchdog timeout select, code 2'b11 disables |
| tick_1ms_i | input | 1 | One-cycle strobe once per millisecond |
| rst_n_o | output | 1 | Registered active-low processor reset |
| bus_inhibit_o | output | 1 | Registered flag telling the serial slave to abort and refuse traffic |

## Verification
The hardest case to reach is a supply drop that lands inside a watchdog reset pulse. The bench first lets the watchdog expire on the shortest period. It then advances the pulse by one tick, pulls the supply flag low and raises it again. It checks that reset still holds at the point where the pulse alone would have ended, and that it releases only after the full power-up count. A START sent in the middle of a pulse, and an SDA fall with SCL low, are also steered to known tick positions, so that a wrong restart shows up as a one-tick shift in the release.

// File: rtl/sup_wd_pkg.sv
package sup_wd_pkg;
  typedef enum logic [1:0] {
    WDSEL_LONG  = 2'b00,
    WDSEL_MID   = 2'b01,
    WDSEL_SHORT = 2'b10,
    WDSEL_OFF   = 2'b11
  } wd_sel_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sup_wd_sync.sv
module sup_wd_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= RST_VAL;
        else if (g == 0) stage_q[g] <= d_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sup_wd_start_det.sv
module sup_wd_start_det (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o
);
  logic sda_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) sda_d <= 1'b1;
    else       sda_d <= sda_s_i;
  end

  assign start_o = scl_s_i & sda_d & ~sda_s_i;
endmodule

// File: rtl/sup_wd_pwr_hold.sv
module sup_wd_pwr_hold #(
  parameter int unsigned PWRUP_MS = 200
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sup_ok_s_i,
  input  logic tick_i,
  output logic sup_rst_o
);
  localparam int unsigned CW = $clog2(PWRUP_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(PWRUP_MS - 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sup_rst_o <= 1'b1;
      hold_cnt  <= '0;
    end else if (!sup_ok_s_i) begin
      sup_rst_o <= 1'b1;
      hold_cnt  <= '0;
    end else if (sup_rst_o && tick_i) begin
      if (hold_cnt == LAST) begin
        sup_rst_o <= 1'b0;
        hold_cnt  <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  // R1: a low synchronized supply flag forces the supply reset next cycle
  a_r1_drop_asserts: assert property (@(posedge clk_i) disable iff (rst_i)
    !sup_ok_s_i |=> sup_rst_o);
  // R2: release only happens on a tick with the supply good
  a_r2_release_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sup_rst_o) |-> $past(tick_i && sup_ok_s_i));
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_wd_pkg::*;
#(
  parameter int unsigned WD_LONG_MS  = 1400,
  parameter int unsigned WD_MID_MS   = 600,
  parameter int unsigned WD_SHORT_MS = 200,
  parameter int unsigned WDRST_MS    = 250
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sup_rst_i,
  input  logic [1:0] sel_i,
  input  logic       tick_i,
  input  logic       start_i,
  output logic       wd_rst_o
);
  localparam int unsigned MAXP = max3(WD_LONG_MS, WD_MID_MS, WD_SHORT_MS);
  localparam int unsigned CW   = $clog2(MAXP + 1);
  localparam int unsigned PW   = $clog2(WDRST_MS + 1);
  localparam logic [PW-1:0] PLS_LAST = PW'(WDRST_MS - 1);

  logic [CW-1:0] wd_cnt;
  logic [PW-1:0] pls_cnt;
  logic [CW-1:0] lim;
  logic          off;

  always_comb begin
    case (wd_sel_e'(sel_i))
      WDSEL_LONG:  lim = CW'(WD_LONG_MS - 1);
      WDSEL_MID:   lim = CW'(WD_MID_MS - 1);
      WDSEL_SHORT: lim = CW'(WD_SHORT_MS - 1);
      default:     lim = '0;
    endcase
  end

  assign off = (wd_sel_e'(sel_i) == WDSEL_OFF);

  always_ff @(posedge clk_i) begin
    if (rst_i || sup_rst_i || off) begin
      wd_cnt   <= '0;
      pls_cnt  <= '0;
      wd_rst_o <= 1'b0;
    end else if (wd_rst_o) begin
      wd_cnt <= '0;
      if (tick_i) begin
        if (pls_cnt == PLS_LAST) begin
          wd_rst_o <= 1'b0;
          pls_cnt  <= '0;
        end else begin
          pls_cnt <= pls_cnt + 1'b1;
        end
      end
    end else if (start_i) begin
      wd_cnt <= '0;
    end else if (tick_i) begin
      if (wd_cnt >= lim) begin
        wd_rst_o <= 1'b1;
        wd_cnt   <= '0;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  // R4: disabled code or supply reset clears the watchdog
  a_r4_held_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (sup_rst_i || off) |=> (!wd_rst_o && wd_cnt == '0));
  // R5: a pulse starts only on a tick
  a_r5_rise_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wd_rst_o) |-> $past(tick_i));
  // R5: a pulse that ends on its own has counted the full width
  a_r5_full_width: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(wd_rst_o) && !$past(sup_rst_i || off)) |-> ($past(pls_cnt) == PLS_LAST));
  // R7: START during a pulse leaves the pulse count alone
  a_r7_start_in_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    (wd_rst_o && start_i && !tick_i && !sup_rst_i && !off) |=> $stable(pls_cnt));
endmodule

// File: rtl/sup_wd_reset.sv
module sup_wd_reset #(
  parameter int unsigned PWRUP_MS    = 200,
  parameter int unsigned WDRST_MS    = 250,
  parameter int unsigned WD_LONG_MS  = 1400,
  parameter int unsigned WD_MID_MS   = 600,
  parameter int unsigned WD_SHORT_MS = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       supply_ok_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] wd_sel_i,
  input  logic       tick_1ms_i,
  output logic       rst_n_o,
  output logic       bus_inhibit_o
);
  logic [2:0] raw_v, sync_v;
  logic       sup_ok_s, scl_s, sda_s;
  logic       start, sup_rst, wd_rst;

  assign raw_v = {supply_ok_i, scl_i, sda_i};

  sup_wd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(raw_v), .q_o(sync_v)
  );

  assign sup_ok_s = sync_v[2];
  assign scl_s    = sync_v[1];
  assign sda_s    = sync_v[0];

  sup_wd_start_det u_start (
    .clk_i(clk_i), .rst_i(rst_i), .scl_s_i(scl_s), .sda_s_i(sda_s), .start_o(start)
  );

  sup_wd_pwr_hold #(.PWRUP_MS(PWRUP_MS)) u_pwr (
    .clk_i(clk_i), .rst_i(rst_i), .sup_ok_s_i(sup_ok_s), .tick_i(tick_1ms_i),
    .sup_rst_o(sup_rst)
  );

  sup_wd_timer #(
    .WD_LONG_MS(WD_LONG_MS), .WD_MID_MS(WD_MID_MS),
    .WD_SHORT_MS(WD_SHORT_MS), .WDRST_MS(WDRST_MS)
  ) u_wd (
    .clk_i(clk_i), .rst_i(rst_i), .sup_rst_i(sup_rst), .sel_i(wd_sel_i),
    .tick_i(tick_1ms_i), .start_i(start), .wd_rst_o(wd_rst)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rst_n_o       <= 1'b0;
      bus_inhibit_o <= 1'b1;
    end else begin
      rst_n_o       <= ~(sup_rst | wd_rst);
      bus_inhibit_o <= sup_rst | wd_rst;
    end
  end

  // R9: inhibit flag and reset output always agree
  a_r9_inhibit_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_inhibit_o == !rst_n_o);
  // R1: supply reset shows at the output one cycle later
  a_r1_out_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    sup_rst |=> !rst_n_o);
endmodule

// File: tb/sup_wd_reset_tb.sv
module sup_wd_reset_tb;
  localparam int PU = 5, PL = 4, LG = 20, MD = 12, SH = 8;

  logic clk = 0, rst = 1, sup = 0, scl = 1, sda = 1, tick = 0;
  logic [1:0] sel = 2'b11;
  logic rst_n, inh;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic rstn; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  sup_wd_reset #(.PWRUP_MS(PU), .WDRST_MS(PL), .WD_LONG_MS(LG),
                 .WD_MID_MS(MD), .WD_SHORT_MS(SH)) u_dut (
    .clk_i(clk), .rst_i(rst), .supply_ok_i(sup), .scl_i(scl), .sda_i(sda),
    .wd_sel_i(sel), .tick_1ms_i(tick), .rst_n_o(rst_n), .bus_inhibit_o(inh)
  );

  // monitor: pop expectations and compare against outputs
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (rst_n !== e.rstn) begin
        failures++;
        $display("FAIL %s rst_n actual=%0b expected=%0b", e.req, rst_n, e.rstn);
      end
      checks++;
      if (inh !== !e.rstn) begin
        failures++;
        $display("FAIL R9 (%s) inhibit actual=%0b expected=%0b", e.req, inh, !e.rstn);
      end
    end
  end

  task automatic expect_rst(input logic rn, input string req);
    exp_t e;
    e.rstn = rn; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      wait_cyc(6);
    end
  endtask

  task automatic set_sup(input logic v);
    @(negedge clk); sup = v;
    wait_cyc(8);
  endtask

  task automatic bus_start();
    sda = 0; wait_cyc(4); scl = 0; wait_cyc(4); sda = 1; wait_cyc(4); scl = 1; wait_cyc(4);
  endtask

  task automatic bus_fall_scl_low();
    scl = 0; wait_cyc(4); sda = 0; wait_cyc(4); sda = 1; wait_cyc(4); scl = 1; wait_cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    expect_rst(0, "R3 during reset");
    @(negedge clk); rst = 0;
    expect_rst(0, "R3 after reset");
    ticks(3);
    expect_rst(0, "R1 supply low holds reset");
    // R2: power-up, interrupted count restarts
    set_sup(1);
    ticks(3);
    set_sup(0);
    expect_rst(0, "R1 low again");
    set_sup(1);
    ticks(PU-1);
    expect_rst(0, "R2 count restarted after drop");
    ticks(1);
    expect_rst(1, "R2 release after full delay");
    // R4 disabled
    ticks(30);
    expect_rst(1, "R4 code 11 disables watchdog");
    // R5 short period
    @(negedge clk); sel = 2'b10;
    ticks(SH-1);
    expect_rst(1, "R4 short period not yet");
    ticks(1);
    expect_rst(0, "R5 expiry pulses reset");
    ticks(PL-1);
    expect_rst(0, "R5 pulse width");
    ticks(1);
    expect_rst(1, "R5 pulse end");
    ticks(SH-1);
    expect_rst(1, "R5 restart timing");
    ticks(1);
    expect_rst(0, "R5 second expiry");
    ticks(PL);
    expect_rst(1, "R5 second pulse end");
    // R6 START restarts
    ticks(5);
    bus_start();
    ticks(SH-1);
    expect_rst(1, "R6 START cleared count");
    ticks(1);
    expect_rst(0, "R6 expiry after START");
    // R7 START in pulse ignored
    ticks(2);
    bus_start();
    ticks(1);
    expect_rst(0, "R7 START does not shorten pulse");
    ticks(1);
    expect_rst(1, "R7 START does not lengthen pulse");
    // R7 SDA fall with SCL low ignored
    ticks(5);
    bus_fall_scl_low();
    ticks(SH-6);
    expect_rst(1, "R7 before expiry");
    ticks(1);
    expect_rst(0, "R7 SDA fall with SCL low ignored");
    ticks(PL);
    expect_rst(1, "R5 pulse end");
    // R4 mid and long codes
    @(negedge clk); sel = 2'b01;
    ticks(MD-1);
    expect_rst(1, "R4 mid not yet");
    ticks(1);
    expect_rst(0, "R4 mid period");
    ticks(PL);
    @(negedge clk); sel = 2'b00;
    ticks(LG-1);
    expect_rst(1, "R4 long not yet");
    ticks(1);
    expect_rst(0, "R4 long period");
    ticks(PL);
    expect_rst(1, "R5 pulse end");
    // R8 supply drop inside pulse
    @(negedge clk); sel = 2'b10;
    ticks(SH);
    expect_rst(0, "R8 pulse started");
    ticks(1);
    set_sup(0);
    set_sup(1);
    ticks(PU-1);
    expect_rst(0, "R8 full power-up delay");
    ticks(1);
    expect_rst(1, "R8 release");
    // R4 selecting 11 cancels a pulse
    ticks(SH);
    expect_rst(0, "R4 pulse before disable");
    @(negedge clk); sel = 2'b11;
    wait_cyc(4);
    expect_rst(1, "R4 code 11 cancels pulse");
    // R1 drop during normal run
    @(negedge clk); sup = 0;
    wait_cyc(5);
    expect_rst(0, "R1 drop within 4 cycles");
    wait (q.size() == 0);
    wait_cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule